// File: doc/BRIEF.md
# Digit-Serial Signed-Digit Magnitude Unit

This unit accepts a radix-2 signed-digit number one digit per clock, most significant digit first. It returns the digits of the number's magnitude in the same order, and it reports the number's sign as soon as that sign is known. It sits in the residue path of a rotation slice. That slice needs the size and the polarity of a residue while the residue is still in redundant form, without first converting it to two's complement.

Each digit is handled on its own, so no carry runs across the word and the work per digit does not depend on the operand length. Leading zero digits leave the sign open. The first nonzero digit fixes the sign. From that digit on, every digit is negated when the sign is negative and passed unchanged otherwise. If an operand has no nonzero digit, it is declared positive on its final digit. A start flag on a digit opens a new operand.

Top module: `sd_abs_serial`

## Requirements
- R1: A digit is two bits {plus, minus}: 2'b10 is +1, 2'b01 is -1, 2'b00 is 0. An input code 2'b11 is taken as 0. An output digit is never 2'b11.
- R2: Every digit accepted with in_valid high gives exactly one output digit with out_valid high, one clock later and in arrival order.
- R3: Output digits that come before the first nonzero input digit of an operand are 2'b00.
- R4: The output digits of an operand, read as a signed-digit number, equal the absolute value of the input operand.
- R5: sign_valid pulses exactly once per operand. When the operand has a nonzero digit, the pulse comes in the output cycle of its first nonzero digit. At that pulse sign_neg is 1 exactly when that digit is -1, and the output digit is +1.
- R6: An operand whose WORD_DIGITS digits are all zero raises sign_valid with its final digit, with sign_neg 0.
- R7: A digit with in_start high is digit 0 of a new operand, even if the previous operand is unfinished. The sign state of the earlier operand does not carry over.
- R8: A cycle with in_valid low gives out_valid low one cycle later and does not change the operand state. The digits on either side of the gap are treated as adjacent.
- R9: After reset, out_valid, sign_valid and sign_neg are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_dig carries a digit this cycle |
| in_start | input | 1 | This digit is the most significant digit of a new operand |
| in_dig | input | 2 | Input digit, {plus, minus} code |
| out_valid | output | 1 | out_dig carries a magnitude digit |
| out_dig | output | 2 | Magnitude digit, {plus, minus} code |
| sign_valid | output | 1 | Sign decision for the current operand is made this cycle |
| sign_neg | output | 1 | Sign decision, 1 means negative; held until the next decision |

## Verification
Random operands are drawn with a random run of leading zeros followed by random digits. This separates operands whose sign is fixed early from operands whose sign is fixed late, and it checks the integer magnitude and the position of the sign pulse for each. Directed operands cover the cases random draws rarely reach: all zeros, a lone -1 or +1 in the final place, a leading -1 followed by mixed digits, inputs with the illegal code, and digit streams broken by idle cycles. An operand cut short by a new start tells apart a design that clears its sign state from one that leaks the old sign into the next operand.

// File: rtl/sdabs_pkg.sv
package sdabs_pkg;

   typedef logic [1:0] sd_digit_t;

   localparam sd_digit_t SD_ZERO = 2'b00;
   localparam sd_digit_t SD_POS  = 2'b10;
   localparam sd_digit_t SD_NEG  = 2'b01;

   // map the unused code onto zero
   function automatic sd_digit_t sd_clean(input sd_digit_t d);
      return (d == 2'b11) ? SD_ZERO : d;
   endfunction

   // digit-level negation: swap the plus and minus rails
   function automatic sd_digit_t sd_negate(input sd_digit_t d);
      return {d[0], d[1]};
   endfunction

   function automatic logic sd_nonzero(input sd_digit_t d);
      return d[1] ^ d[0];
   endfunction

endpackage

// File: rtl/sdabs_digit_unit.sv
module sdabs_digit_unit
   import sdabs_pkg::*;
(
   input  sd_digit_t raw_dig,
   input  logic      flip,
   output sd_digit_t clean_dig,
   output sd_digit_t mag_dig
);

   always_comb begin
      clean_dig = sd_clean(raw_dig);
      mag_dig   = flip ? sd_negate(clean_dig) : clean_dig;
   end

endmodule

// File: rtl/sdabs_sign_tracker.sv
module sdabs_sign_tracker
   import sdabs_pkg::*;
#(
   parameter int WORD_DIGITS = 32
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      dig_valid,
   input  logic      dig_start,
   input  sd_digit_t dig,
   output logic      flip_now,
   output logic      decide_now
);

   localparam int CNT_W = (WORD_DIGITS > 2) ? $clog2(WORD_DIGITS) : 1;
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_DIGITS - 1);

   logic             found_q, neg_q;
   logic [CNT_W-1:0] pos_q;

   logic             base_found, base_neg, hit, at_last;
   logic [CNT_W-1:0] pos_now;

   always_comb begin
      base_found = dig_start ? 1'b0 : found_q;
      base_neg   = dig_start ? 1'b0 : neg_q;
      pos_now    = dig_start ? '0   : pos_q;
      hit        = !base_found && sd_nonzero(dig);
      at_last    = (pos_now == LAST_POS);
      flip_now   = hit ? (dig == SD_NEG) : base_neg;
      decide_now = dig_valid && !base_found && (hit || at_last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found_q <= 1'b0;
         neg_q   <= 1'b0;
         pos_q   <= '0;
      end else if (dig_valid) begin
         found_q <= base_found || hit || at_last;
         neg_q   <= flip_now;
         pos_q   <= at_last ? pos_now : pos_now + 1'b1;
      end
   end

   // R8
   state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dig_valid |=> ($stable(found_q) && $stable(neg_q) && $stable(pos_q)));

   // R5
   single_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_valid && !dig_start && found_q) |-> !decide_now);

endmodule

// File: rtl/sdabs_out_stage.sv
module sdabs_out_stage
   import sdabs_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      st_valid,
   input  sd_digit_t st_dig,
   input  logic      st_decide,
   input  logic      st_neg,
   output logic      o_valid,
   output sd_digit_t o_dig,
   output logic      o_decide,
   output logic      o_neg
);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_valid  <= 1'b0;
               o_dig    <= SD_ZERO;
               o_decide <= 1'b0;
               o_neg    <= 1'b0;
            end else begin
               o_valid  <= st_valid;
               o_dig    <= st_valid ? st_dig : SD_ZERO;
               o_decide <= st_decide;
               if (st_decide) o_neg <= st_neg;
            end
         end

         // R2
         out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_valid |=> o_valid);

         // R8
         idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !st_valid |=> !o_valid);
      end else begin : g_comb
         logic neg_hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         neg_hold_q <= 1'b0;
            else if (st_decide) neg_hold_q <= st_neg;
         end
         always_comb begin
            o_valid  = st_valid;
            o_dig    = st_valid ? st_dig : SD_ZERO;
            o_decide = st_decide;
            o_neg    = st_decide ? st_neg : neg_hold_q;
         end
      end
   endgenerate

endmodule

// File: rtl/sd_abs_serial.sv
module sd_abs_serial
   import sdabs_pkg::*;
#(
   parameter int WORD_DIGITS = 32,
   parameter bit OUT_REG     = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_start,
   input  logic [1:0] in_dig,
   output logic       out_valid,
   output logic [1:0] out_dig,
   output logic       sign_valid,
   output logic       sign_neg
);

   generate
      if (WORD_DIGITS < 2) begin : g_bad_len
         $error("sd_abs_serial: WORD_DIGITS must be at least 2");
      end
   endgenerate

   sd_digit_t clean_dig, mag_dig;
   logic      flip_now, decide_now;

   sdabs_digit_unit u_digit (
      .raw_dig   (in_dig),
      .flip      (flip_now),
      .clean_dig (clean_dig),
      .mag_dig   (mag_dig)
   );

   sdabs_sign_tracker #(.WORD_DIGITS(WORD_DIGITS)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .dig_valid  (in_valid),
      .dig_start  (in_start),
      .dig        (clean_dig),
      .flip_now   (flip_now),
      .decide_now (decide_now)
   );

   sdabs_out_stage #(.OUT_REG(OUT_REG)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_valid (in_valid),
      .st_dig   (mag_dig),
      .st_decide(decide_now),
      .st_neg   (flip_now),
      .o_valid  (out_valid),
      .o_dig    (out_dig),
      .o_decide (sign_valid),
      .o_neg    (sign_neg)
   );

   // R1
   no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_dig != 2'b11));

   // R5
   decide_with_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sign_valid |-> out_valid);

   // R5
   lead_digit_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sign_valid && out_dig != SD_ZERO) |-> (out_dig == SD_POS));

   // R9
   sign_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sign_valid |-> $stable(sign_neg));

endmodule

// File: tb/sd_abs_serial_tb.sv
module sd_abs_serial_tb;

   localparam int N = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_start = 1'b0;
   logic [1:0] in_dig = 2'b00;
   logic       out_valid, sign_valid, sign_neg;
   logic [1:0] out_dig;

   sd_abs_serial #(.WORD_DIGITS(N), .OUT_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
      .in_dig(in_dig), .out_valid(out_valid), .out_dig(out_dig),
      .sign_valid(sign_valid), .sign_neg(sign_neg)
   );

   always #10 clk = ~clk;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   logic [1:0] op_d [N];
   int  r_pulses, r_pulse_pos, r_lead_bad, r_code_bad, r_valid_bad;
   bit  r_neg;
   longint r_mag;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int dval(input logic [1:0] d);
      if (d == 2'b10) return 1;
      if (d == 2'b01) return -1;
      return 0;
   endfunction

   task automatic idle_cycle();
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0; in_dig = 2'b00;
      @(posedge clk); #2;
      if (out_valid !== 1'b0) r_valid_bad++;
   endtask

   // drive an operand from op_d, optionally with idle gaps, up to 'count' digits
   task automatic drive_op(input int count, input bit stalls);
      int fz;
      fz = -1;
      for (int i = 0; i < N; i++)
         if (fz < 0 && dval(op_d[i]) != 0) fz = i;
      r_pulses = 0; r_pulse_pos = -1; r_lead_bad = 0; r_code_bad = 0;
      r_valid_bad = 0; r_mag = 0; r_neg = 1'b0;
      for (int i = 0; i < count; i++) begin
         if (stalls && ($urandom % 3 == 0)) idle_cycle();
         @(negedge clk);
         in_valid = 1'b1; in_start = (i == 0); in_dig = op_d[i];
         @(posedge clk); #2;
         if (out_valid !== 1'b1) r_valid_bad++;
         if (out_dig == 2'b11) r_code_bad++;
         if ((fz < 0 || i < fz) && out_dig != 2'b00) r_lead_bad++;
         r_mag = r_mag * 2 + dval(out_dig);
         if (sign_valid) begin
            r_pulses++; r_pulse_pos = i; r_neg = sign_neg;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0; in_dig = 2'b00;
   endtask

   task automatic run_op(input bit stalls);
      longint val;
      int fz;
      bit eneg;
      val = 0; fz = -1; eneg = 1'b0;
      for (int i = 0; i < N; i++) begin
         val = val * 2 + dval(op_d[i]);
         if (fz < 0 && dval(op_d[i]) != 0) begin
            fz = i; eneg = (dval(op_d[i]) < 0);
         end
      end
      drive_op(N, stalls);
      chk(r_valid_bad == 0, "R2 R8 out_valid pattern", r_valid_bad, 0);
      chk(r_code_bad == 0, "R1 output code", r_code_bad, 0);
      chk(r_lead_bad == 0, "R3 leading digits", r_lead_bad, 0);
      chk(r_mag == ((val < 0) ? -val : val), "R4 magnitude", r_mag, (val < 0) ? -val : val);
      chk(r_pulses == 1, "R5 pulse count", r_pulses, 1);
      if (fz < 0) begin
         chk(r_pulse_pos == N - 1, "R6 pulse position", r_pulse_pos, N - 1);
         chk(r_neg == 1'b0, "R6 sign", r_neg, 0);
      end else begin
         chk(r_pulse_pos == fz, "R5 pulse position", r_pulse_pos, fz);
         chk(r_neg == eneg, "R5 sign", r_neg, eneg);
      end
   endtask

   function automatic logic [1:0] rdig(input bit allow_bad);
      int r;
      r = $urandom % 16;
      if (allow_bad && r == 0) return 2'b11;
      if (r < 6) return 2'b10;
      if (r < 11) return 2'b01;
      return 2'b00;
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20241));
      #35;
      // R9: reset state
      chk(out_valid == 1'b0 && sign_valid == 1'b0 && sign_neg == 1'b0,
          "R9 reset outputs", {out_valid, sign_valid, sign_neg}, 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R6: all zero
      for (int i = 0; i < N; i++) op_d[i] = 2'b00;
      run_op(1'b0);
      // R5: lone -1 in the last place
      op_d[N-1] = 2'b01;
      run_op(1'b0);
      // lone +1 in the last place
      op_d[N-1] = 2'b10;
      run_op(1'b0);
      // R4: leading -1 then mixed digits
      for (int i = 0; i < N; i++) op_d[i] = (i % 3 == 0) ? 2'b10 : 2'b01;
      op_d[0] = 2'b01;
      run_op(1'b0);
      // R1: illegal codes among leading digits, then a -1
      for (int i = 0; i < N; i++) op_d[i] = (i < 4) ? 2'b11 : rdig(1'b0);
      op_d[4] = 2'b01;
      run_op(1'b0);
      // R8: stalls inside an operand with a negative residue
      for (int i = 0; i < N; i++) op_d[i] = rdig(1'b0);
      op_d[0] = 2'b00; op_d[1] = 2'b01;
      run_op(1'b1);

      // R7: aborted negative operand, then a positive one
      for (int i = 0; i < N; i++) op_d[i] = 2'b01;
      drive_op(5, 1'b0);
      for (int i = 0; i < N; i++) op_d[i] = (i < 3) ? 2'b00 : 2'b10;
      op_d[N-1] = 2'b01;
      run_op(1'b0);
      chk(r_neg == 1'b0, "R7 sign after restart", r_neg, 0);
      chk(r_pulse_pos == 3, "R7 pulse position after restart", r_pulse_pos, 3);

      // random operands
      for (int k = 0; k < 300; k++) begin
         int lz;
         lz = $urandom % (N + 1);
         for (int i = 0; i < N; i++) op_d[i] = (i < lz) ? 2'b00 : rdig(1'b1);
         run_op(k % 4 == 0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule